// File: doc/BRIEF.md
# Fixed-Priority Vectored Interrupt Controller

This block collects interrupt requests for a small 8-bit processor and gives the processor one vector at a time. Sixteen interrupt slots are arbitrated with fixed priority. Fifteen of them are maskable hardware sources: five edge-sensitive pins with selectable polarity, eight single-cycle peripheral pulses, a key-wakeup source, and a shared slot that is fed either by a converter-trigger pin or by a conversion-done pulse. The sixteenth slot is a software break that nothing can mask. Every hardware event is latched in a request bit. A maskable request can win only when its enable bit is set and the global disable flag is clear.

The processor sees `irq` while any request can be accepted and answers with a one-cycle `ack`. The handshake uses two states. In `S_IDLE` the controller waits. When `ack` arrives while `irq` is high, it takes the accept transition to `S_GRANT`. `S_GRANT` lasts exactly one cycle, during which `vec_valid` is high with the winner's vector address and priority index. The controller then returns to `S_IDLE` unconditionally. The accept edge clears the winner's request bit and sets the disable flag. Software reads and writes the request, enable, configuration and disable registers through a small register port.

Priority level 1 is reserved for reset, which lies outside this block. The interrupt slots therefore occupy levels 2 to 17.

Top module: `prio_vec_intc`

## Requirements
- R1: After reset the request, enable, polarity and select registers read 0, the disable flag reads 1, `irq` is 0 and `vec_valid` is 0.
- R2: `irq` is 1 in `S_IDLE` exactly when the break is pending, or when some slot has both its request and enable bits at 1 while the disable flag is 0.
- R3: The winning slot is the lowest-numbered acceptable slot. Slots 0..15 are: INT0, INT1, serial-1 receive, serial-1 transmit, timer X, timer Y, timer 2, timer 3, CNTR0, CNTR1, timer 1, INT2, serial-2, key, converter, break. Peripheral pulse bits `per_evt[7:0]` feed slots 2,3,4,5,6,7,10,12 in that order.
- R4: When `ack` is 1 and `irq` is 1 in `S_IDLE`, the next cycle is `S_GRANT`. In that cycle `vec_valid` is 1 for exactly one cycle, the winner's request bit reads 0, and the disable flag reads 1.
- R5: For winning slot s, `vec_addr` = 0xFFFA − 2·s, which is the low-byte address of the pair; the high byte is at +1. `vec_idx` = s + 2.
- R6: Register map: address 0 is request, with bit s for slot s and bit 15 showing the pending break. Address 1 is enable, bits 14..0. Address 2 is configuration: bits 4..0 are pin polarity and bit 8 is the converter select. Address 3 bit 0 is the disable flag. Writing 0 to a request bit clears it, and writing 1 has no effect.
- R7: If a hardware event and a software clear reach the same request bit in the same cycle, the bit ends up set.
- R8: The break (`brk_req` pulse) sets a pending bit that ignores enables and the disable flag. It is cleared only by its own acceptance.
- R9: The pins `pin_ext[4:0]` are INT0, INT1, CNTR0, CNTR1 and INT2. Each passes through a two-flop synchronizer and sets its request on a rising edge when its polarity bit is 1, or on a falling edge when it is 0. The request bit reads 1 after the third clock edge following the pin change. Changing the polarity while the pin is steady sets no request.
- R10: The key slot sets on a 1-to-0 change of the AND of all synchronized `key_pins` bits whose `key_inmode` bit is 1. A falling bit that is not in input mode has no effect.
- R11: With select 0, the converter slot follows `adc_done` and ignores the `pin_adt` fall. With select 1, it follows the synchronized `pin_adt` falling edge and ignores `adc_done`.
- R12: An `ack` while `irq` is 0 is ignored: `vec_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational) |
| pin_ext | input | 5 | Edge-selectable interrupt pins |
| pin_adt | input | 1 | Converter-trigger pin, falling edge |
| key_pins | input | 8 | Key port input levels |
| key_inmode | input | 8 | 1 = port bit is in input mode |
| per_evt | input | 8 | Single-cycle peripheral event pulses |
| adc_done | input | 1 | Conversion-complete pulse |
| brk_req | input | 1 | Software break pulse |
| ack | input | 1 | Processor accepts the interrupt |
| irq | output | 1 | An acceptable request exists |
| vec_valid | output | 1 | Vector outputs valid (state `S_GRANT`) |
| vec_addr | output | 16 | Low-byte vector address |
| vec_idx | output | 5 | Priority level of the granted slot (2..17) |

## Verification
A peripheral pulse is visible in the request register and on `irq` one edge after it is driven, while a pin change needs three edges. The bench waits exactly that many edges and also samples one edge early to confirm that the request has not yet appeared. The granted vector appears in the cycle after the edge that samples `ack`. A driver task queues the expected vector as it raises `ack`, and a monitor compares `vec_valid` cycles against that queue on falling edges. Any grant that was not expected, including one after an ignored `ack`, is reported as a failure.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int NSLOT  = 16;
    localparam int NMASK  = NSLOT - 1;
    localparam int SLOT_W = $clog2(NSLOT);
    localparam int IDX_W  = 5;
    localparam int DW     = 16;

    localparam logic [1:0] A_REQ   = 2'd0;
    localparam logic [1:0] A_EN    = 2'd1;
    localparam logic [1:0] A_CFG   = 2'd2;
    localparam logic [1:0] A_IFLAG = 2'd3;

    localparam logic [DW-1:0] VEC_TOP = 16'hFFFA;

    typedef enum logic [0:0] {
        S_IDLE  = 1'b0,
        S_GRANT = 1'b1
    } hs_state_t;

    function automatic logic [DW-1:0] slot_vec(input logic [SLOT_W-1:0] s);
        return VEC_TOP - {{(DW-SLOT_W-1){1'b0}}, s, 1'b0};
    endfunction

    function automatic logic [IDX_W-1:0] slot_idx(input logic [SLOT_W-1:0] s);
        return {{(IDX_W-SLOT_W){1'b0}}, s} + IDX_W'(2);
    endfunction
endpackage

// File: rtl/vic_sync.sv
module vic_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] chain [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[g] <= '0;
                else if (g == 0) chain[g] <= din;
                else chain[g] <= chain[(g == 0) ? 0 : g - 1];
            end
        end
    endgenerate

    assign dout = chain[STAGES-1];
endmodule

// File: rtl/vic_edge.sv
module vic_edge #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] rise_sel,
    output logic [W-1:0] evt
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else prev_q <= lvl;
    end

    // Edges are taken from real level changes, so a polarity flip alone never fires.
    always_comb begin
        for (int i = 0; i < W; i++)
            evt[i] = rise_sel[i] ? (lvl[i] & ~prev_q[i]) : (~lvl[i] & prev_q[i]);
    end
endmodule

// File: rtl/vic_arb.sv
module vic_arb #(
    parameter int N  = 16,
    localparam int IW = $clog2(N)
) (
    input  logic [N-1:0]  pend,
    output logic          any,
    output logic [IW-1:0] win
);
    always_comb begin
        any = |pend;
        win = '0;
        for (int i = N - 1; i >= 0; i--)
            if (pend[i]) win = IW'(i);
    end
endmodule

// File: rtl/prio_vec_intc.sv
module prio_vec_intc
    import vic_pkg::*;
#(
    parameter int KEYW        = 8,
    parameter int NPER        = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            reg_we,
    input  logic [1:0]      reg_addr,
    input  logic [15:0]     reg_wdata,
    output logic [15:0]     reg_rdata,
    input  logic [4:0]      pin_ext,
    input  logic            pin_adt,
    input  logic [KEYW-1:0] key_pins,
    input  logic [KEYW-1:0] key_inmode,
    input  logic [NPER-1:0] per_evt,
    input  logic            adc_done,
    input  logic            brk_req,
    input  logic            ack,
    output logic            irq,
    output logic            vec_valid,
    output logic [15:0]     vec_addr,
    output logic [4:0]      vec_idx
);
    localparam int NPIN  = 5;
    localparam int SYN_W = NPIN + 1 + KEYW;
    localparam logic [SLOT_W-1:0] BRK_SLOT = SLOT_W'(NSLOT - 1);

    hs_state_t state_q, state_d;

    logic [NMASK-1:0] req_q, en_q, set_hw, clr_sw, acc_mask;
    logic [NPIN-1:0]  pol_q, pin_evt;
    logic             adsel_q, iflag_q, brk_q;
    logic [SYN_W-1:0] syn;
    logic [1:0]       misc_evt;
    logic             key_and, any, accept;
    logic [SLOT_W-1:0] win;

    vic_sync #(.W(SYN_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .din({key_pins, pin_adt, pin_ext}), .dout(syn)
    );

    assign key_and = &(syn[NPIN+1 +: KEYW] | ~key_inmode);

    vic_edge #(.W(NPIN)) u_pin_edge (
        .clk(clk), .rst_n(rst_n), .lvl(syn[NPIN-1:0]), .rise_sel(pol_q), .evt(pin_evt)
    );

    vic_edge #(.W(2)) u_fall_edge (
        .clk(clk), .rst_n(rst_n), .lvl({key_and, syn[NPIN]}), .rise_sel(2'b00), .evt(misc_evt)
    );

    // Slot map, highest priority first.
    always_comb begin
        set_hw     = '0;
        set_hw[0]  = pin_evt[0];
        set_hw[1]  = pin_evt[1];
        set_hw[2]  = per_evt[0];
        set_hw[3]  = per_evt[1];
        set_hw[4]  = per_evt[2];
        set_hw[5]  = per_evt[3];
        set_hw[6]  = per_evt[4];
        set_hw[7]  = per_evt[5];
        set_hw[8]  = pin_evt[2];
        set_hw[9]  = pin_evt[3];
        set_hw[10] = per_evt[6];
        set_hw[11] = pin_evt[4];
        set_hw[12] = per_evt[7];
        set_hw[13] = misc_evt[1];
        set_hw[14] = adsel_q ? misc_evt[0] : adc_done;
    end

    vic_arb #(.N(NSLOT)) u_arb (
        .pend({brk_q, req_q & en_q & {NMASK{~iflag_q}}}), .any(any), .win(win)
    );

    assign irq    = (state_q == S_IDLE) && any;
    assign accept = irq && ack;

    always_comb begin
        clr_sw   = (reg_we && reg_addr == A_REQ) ? ~reg_wdata[NMASK-1:0] : '0;
        acc_mask = '0;
        if (accept && win != BRK_SLOT) acc_mask[win] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q   <= '0;
            en_q    <= '0;
            pol_q   <= '0;
            adsel_q <= 1'b0;
            iflag_q <= 1'b1;
            brk_q   <= 1'b0;
        end else begin
            req_q <= (req_q & ~clr_sw & ~acc_mask) | set_hw;
            brk_q <= brk_req | (brk_q & ~(accept && win == BRK_SLOT));
            if (reg_we && reg_addr == A_EN) en_q <= reg_wdata[NMASK-1:0];
            if (reg_we && reg_addr == A_CFG) begin
                pol_q   <= reg_wdata[NPIN-1:0];
                adsel_q <= reg_wdata[8];
            end
            if (accept) iflag_q <= 1'b1;
            else if (reg_we && reg_addr == A_IFLAG) iflag_q <= reg_wdata[0];
        end
    end

    always_comb begin
        unique case (reg_addr)
            A_REQ:   reg_rdata = {brk_q, req_q};
            A_EN:    reg_rdata = {1'b0, en_q};
            A_CFG:   reg_rdata = {7'd0, adsel_q, 3'd0, pol_q};
            A_IFLAG: reg_rdata = {15'd0, iflag_q};
            default: reg_rdata = '0;
        endcase
    end

    // Handshake state register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:  if (accept) state_d = S_GRANT;
            S_GRANT: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs: vector latched on accept, valid while in S_GRANT.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_addr <= '0;
            vec_idx  <= '0;
        end else if (accept) begin
            vec_addr <= slot_vec(win);
            vec_idx  <= slot_idx(win);
        end
    end

    assign vec_valid = (state_q == S_GRANT);

    assert_grant_one_cycle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |=> !vec_valid);

    assert_accept_masks_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && ack) |=> (iflag_q && vec_valid));

    assert_disabled_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (iflag_q && !brk_q) |-> !irq);

    assert_sw_no_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_addr == A_REQ && set_hw == '0) |=> ((req_q & ~$past(req_q)) == '0));

    assert_vec_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> (vec_idx >= 5'd2 && vec_idx <= 5'd17 && !vec_addr[0]));
endmodule

// File: tb/sim_prio_vec_intc.sv
`timescale 1ns/1ps
module sim_prio_vec_intc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic [4:0]  pin_ext = 5'h1F;
    logic        pin_adt = 1'b1;
    logic [7:0]  key_pins = 8'hFF;
    logic [7:0]  key_inmode = 8'h0F;
    logic [7:0]  per_evt = 8'h00;
    logic        adc_done = 1'b0;
    logic        brk_req = 1'b0;
    logic        ack = 1'b0;
    logic        irq, vec_valid;
    logic [15:0] vec_addr;
    logic [4:0]  vec_idx;

    int total = 0;
    int bad = 0;
    logic [20:0] expq[$];

    always #4 clk = ~clk;

    prio_vec_intc u0 (.*);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [15:0] d);
        @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_we = 1'b0;
    endtask

    task automatic rdchk(input logic [1:0] a, input logic [15:0] exp, input string tag);
        @(negedge clk); reg_addr = a; #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic irqchk(input logic exp, input string tag);
        @(negedge clk); #1;
        chk(tag, irq, exp);
    endtask

    task automatic pulse(input logic [7:0] p, input logic ad, input logic bk, input logic clr);
        @(negedge clk);
        per_evt = p; adc_done = ad; brk_req = bk;
        if (clr) begin reg_we = 1'b1; reg_addr = 2'd0; reg_wdata = 16'h0000; end
        @(negedge clk);
        per_evt = 8'h00; adc_done = 1'b0; brk_req = 1'b0; reg_we = 1'b0;
    endtask

    task automatic do_ack(input logic push, input logic [4:0] idx, input logic [15:0] va);
        @(negedge clk);
        if (push) expq.push_back({idx, va});
        ack = 1'b1;
        @(negedge clk); ack = 1'b0;
    endtask

    // Monitor: compares each grant against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && vec_valid) begin
            if (expq.size() == 0) begin
                chk("R12 unexpected grant", 1, 0);
            end else begin
                logic [20:0] e;
                e = expq.pop_front();
                chk("R4/R5 grant vector", {vec_idx, vec_addr}, e);
            end
        end
    end

    initial begin
        #200000;
        chk("watchdog", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        irqchk(1'b0, "R1 irq");
        chk("R1 vec_valid", vec_valid, 0);
        rdchk(2'd0, 16'h0000, "R1 req");
        rdchk(2'd1, 16'h0000, "R1 en");
        rdchk(2'd2, 16'h0000, "R1 cfg");
        rdchk(2'd3, 16'h0001, "R1 iflag");

        wr(2'd1, 16'h7FFF);
        rdchk(2'd1, 16'h7FFF, "R6 en readback");

        // timer X pulse while disabled (R2)
        pulse(8'h04, 0, 0, 0);
        rdchk(2'd0, 16'h0010, "R2 req latched");
        irqchk(1'b0, "R2 disabled flag blocks");
        wr(2'd3, 16'h0000);
        irqchk(1'b1, "R2 irq raised");
        do_ack(1, 5'd6, 16'hFFF2);
        rdchk(2'd3, 16'h0001, "R4 flag set");
        rdchk(2'd0, 16'h0000, "R4 req cleared");

        // R3 priority between slots 2 and 7
        wr(2'd3, 16'h0000);
        pulse(8'h21, 0, 0, 0);
        do_ack(1, 5'd4, 16'hFFF6);
        rdchk(2'd0, 16'h0080, "R3 loser stays");
        wr(2'd3, 16'h0000);
        do_ack(1, 5'd9, 16'hFFEC);

        // R12 ack with nothing pending
        wr(2'd3, 16'h0000);
        irqchk(1'b0, "R12 idle");
        do_ack(0, 5'd0, 16'h0);
        @(negedge clk);
        chk("R12 no grant", vec_valid, 0);

        // R2 per-slot mask, R6 clear by 0
        wr(2'd1, 16'h7BFF);
        pulse(8'h40, 0, 0, 0);
        rdchk(2'd0, 16'h0400, "R2 masked req");
        irqchk(1'b0, "R2 masked irq");
        wr(2'd0, 16'h0000);
        rdchk(2'd0, 16'h0000, "R6 clear by 0");
        wr(2'd1, 16'h7FFF);
        wr(2'd0, 16'hFFFF);
        rdchk(2'd0, 16'h0000, "R6 write 1 no set");

        // R7 set wins over same-cycle clear
        pulse(8'h80, 0, 0, 1);
        rdchk(2'd0, 16'h1000, "R7 set wins");
        do_ack(1, 5'd14, 16'hFFE2);

        // R8 break ignores masks (flag now 1)
        wr(2'd1, 16'h0000);
        pulse(8'h00, 0, 1, 0);
        rdchk(2'd0, 16'h8000, "R8 break pending");
        irqchk(1'b1, "R8 irq");
        do_ack(1, 5'd17, 16'hFFDC);
        rdchk(2'd0, 16'h0000, "R8 break cleared");
        wr(2'd1, 16'h7FFF);

        // R9 INT0 falling, then polarity flip
        @(negedge clk); pin_ext[0] = 1'b0;
        @(negedge clk);
        rdchk(2'd0, 16'h0000, "R9 not yet after 2 edges");
        rdchk(2'd0, 16'h0001, "R9 fall after 3 edges");
        wr(2'd3, 16'h0000);
        do_ack(1, 5'd2, 16'hFFFA);
        wr(2'd2, 16'h0001);
        repeat (3) @(negedge clk);
        rdchk(2'd0, 16'h0000, "R9 polarity change no request");
        @(negedge clk); pin_ext[0] = 1'b1;
        repeat (2) @(negedge clk);
        rdchk(2'd0, 16'h0001, "R9 rising selected");
        wr(2'd0, 16'h0000);

        // R10 key AND
        @(negedge clk); key_pins[7] = 1'b0;
        repeat (3) @(negedge clk);
        rdchk(2'd0, 16'h0000, "R10 non-input bit ignored");
        @(negedge clk); key_pins[0] = 1'b0;
        repeat (2) @(negedge clk);
        rdchk(2'd0, 16'h2000, "R10 key fall");
        wr(2'd0, 16'h0000);

        // R11 shared slot select
        @(negedge clk); pin_adt = 1'b0;
        repeat (3) @(negedge clk);
        rdchk(2'd0, 16'h0000, "R11 pin ignored sel0");
        pulse(8'h00, 1, 0, 0);
        rdchk(2'd0, 16'h4000, "R11 done sel0");
        wr(2'd0, 16'h0000);
        wr(2'd2, 16'h0101);
        pulse(8'h00, 1, 0, 0);
        rdchk(2'd0, 16'h0000, "R11 done ignored sel1");
        @(negedge clk); pin_adt = 1'b1;
        repeat (3) @(negedge clk);
        @(negedge clk); pin_adt = 1'b0;
        repeat (2) @(negedge clk);
        rdchk(2'd0, 16'h4000, "R11 pin fall sel1");

        repeat (3) @(negedge clk);
        chk("R4 scoreboard drained", expq.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule